// File: doc/BRIEF.md
# Word-Disable Line Compaction Network

This datapath builds one fault-free logical cache line from two physical lines that share a set. It is meant for caches that repair at word granularity instead of retiring whole blocks. Each physical line has a word fault mask, kept beside its tag, with one bit per data word. A set bit means that word is broken and must never carry data. In paired mode the two lines are merged, which halves both capacity and associativity. Each physical line gives its first `WORDS/2` healthy words, in rising word order. Line A fills the lower half of the logical line and line B fills the upper half. In direct mode the masks are ignored and line A passes through unchanged.

The read side removes faulty words with a chain of `WORDS/2` shift-multiplexer stages per physical line. Each stage discards the lowest remaining faulty word and slides the words above it down by one slot. The write side mirrors this. A chain of insertion stages opens a gap at each faulty position, and a per-word enable vector marks the slots that may be written. If either line has more than `WORDS/2` faulty words, the pair cannot supply a full logical line and the error flag is raised. Both sides are registered, so each adds exactly one cycle of latency.

Top module: `wdc_line_compactor`

## Requirements
- R1: In direct mode (`paired_i`=0) a read returns `rd_a_i` unchanged as `rd_line_o`, with `rd_err_o`=0 and `rd_ok_o`=1, whatever the masks hold.
- R2: In paired mode with no error, logical words 0..`WORDS/2`-1 are the healthy words of line A (mask bit 0) in rising word index order, lowest first.
- R3: In paired mode with no error, logical words `WORDS/2`..`WORDS`-1 are the healthy words of line B, taken in the same rising order.
- R4: A line with exactly `WORDS/2` faulty words is still repaired without error (it supplies its only `WORDS/2` healthy words).
- R5: In paired mode, if either mask has more than `WORDS/2` bits set, then `rd_err_o`=1, `rd_ok_o`=0 and `rd_line_o` is all zeros.
- R6: Every read and write result appears exactly one clock edge after its request. `rd_vld_o` and `wr_vld_o` are set only in the cycle after a request, and the write enables are all clear in any cycle that does not follow a write request.
- R7: A paired write without error sends logical words 0..`WORDS/2`-1 to the first `WORDS/2` healthy positions of line A, and the upper half to those of line B. Exactly `WORDS/2` enable bits are set per line, and none is set on a faulty position.
- R8: A direct write places `wr_line_i` on `wr_a_o` with every enable of line A set and no enable of line B set, whatever the masks hold.
- R9: A paired write whose masks show more than `WORDS/2` faults in either line raises `wr_err_o` and sets no enable on either line.
- R10: While `rst_n` is low, all valid, ok, error and enable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| paired_i | input | 1 | 1 = merge two lines with word repair, 0 = direct use of line A |
| mask_a_i | input | WORDS | Fault mask of line A, bit i set = word i faulty |
| mask_b_i | input | WORDS | Fault mask of line B |
| rd_vld_i | input | 1 | Read request |
| rd_a_i | input | WORDS*WORD_W | Physical line A read data, word i at bits [i*WORD_W +: WORD_W] |
| rd_b_i | input | WORDS*WORD_W | Physical line B read data |
| wr_vld_i | input | 1 | Write request |
| wr_line_i | input | WORDS*WORD_W | Logical line to be written |
| rd_vld_o | output | 1 | Read result present |
| rd_ok_o | output | 1 | Read result present and usable |
| rd_err_o | output | 1 | Read result present but the pair has too many faults |
| rd_line_o | output | WORDS*WORD_W | Aligned logical line |
| wr_vld_o | output | 1 | Write result present |
| wr_err_o | output | 1 | Write rejected for too many faults |
| wr_a_o | output | WORDS*WORD_W | Write data for physical line A |
| wr_b_o | output | WORDS*WORD_W | Write data for physical line B |
| wr_be_a_o | output | WORDS | Per-word write enables for line A |
| wr_be_b_o | output | WORDS | Per-word write enables for line B |

## Verification
The bench covers several mask shapes. Faults at the lowest and highest word catch a chain that handles only one end. Alternating masks catch a stage that shifts by two, or that skips a fault sitting next to another. Exactly four faults per line is the full-tolerance boundary: a design with an off-by-one tolerance would flag an error there, while one that runs out of stages would leave a faulty word in the output. Five faults in one line only, in either A or B, checks that errors are raised per line and not on the combined count. A direct-mode case with all-ones masks catches a design that still applies the masks when they should be ignored. On the write side, the bench compares only the enabled words. This exposes a scatter that is off by one position or that writes into a broken word.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_PAIRED = 1'b1
    } wdc_mode_e;
endpackage

// File: rtl/wdc_squeeze_stage.sv
// One removal step: drops the lowest flagged word and slides the rest down.
module wdc_squeeze_stage #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic [WORDS*WORD_W-1:0] data_i,
    input  logic [WORDS-1:0]        hole_i,
    output logic [WORDS*WORD_W-1:0] data_o,
    output logic [WORDS-1:0]        hole_o
);
    logic [WORDS-1:0]        first_hole;
    logic [WORDS-1:0]        keep;
    logic [WORDS*WORD_W-1:0] down_data;
    logic [WORDS-1:0]        down_hole;

    assign first_hole = hole_i & (~hole_i + 1'b1);
    assign keep       = first_hole - 1'b1;   // all ones when nothing to drop
    assign down_data  = data_i >> WORD_W;
    assign down_hole  = hole_i >> 1;

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            if (keep[i]) begin
                data_o[i*WORD_W +: WORD_W] = data_i[i*WORD_W +: WORD_W];
                hole_o[i]                  = hole_i[i];
            end else begin
                data_o[i*WORD_W +: WORD_W] = down_data[i*WORD_W +: WORD_W];
                hole_o[i]                  = down_hole[i];
            end
        end
    end
endmodule

// File: rtl/wdc_spread_stage.sv
// One insertion step: opens a gap at the lowest pending fault and slides the rest up.
module wdc_spread_stage #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic [WORDS*WORD_W-1:0] data_i,
    input  logic [WORDS-1:0]        pend_i,
    output logic [WORDS*WORD_W-1:0] data_o,
    output logic [WORDS-1:0]        pend_o
);
    logic [WORDS-1:0]        gap;
    logic [WORDS-1:0]        keep;
    logic [WORDS*WORD_W-1:0] up_data;

    assign gap     = pend_i & (~pend_i + 1'b1);
    assign keep    = gap - 1'b1;
    assign up_data = data_i << WORD_W;
    assign pend_o  = pend_i & ~gap;

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            if (keep[i])
                data_o[i*WORD_W +: WORD_W] = data_i[i*WORD_W +: WORD_W];
            else if (gap[i])
                data_o[i*WORD_W +: WORD_W] = '0;
            else
                data_o[i*WORD_W +: WORD_W] = up_data[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/wdc_half_gather.sv
// Read side for one physical line: WORDS/2 squeeze stages in a chain.
module wdc_half_gather #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic [WORDS*WORD_W-1:0]     line_i,
    input  logic [WORDS-1:0]            mask_i,
    output logic [(WORDS/2)*WORD_W-1:0] half_o
);
    localparam int HALF   = WORDS / 2;
    localparam int HALF_W = HALF * WORD_W;

    logic [WORDS*WORD_W-1:0] d_s [HALF+1];
    logic [WORDS-1:0]        h_s [HALF+1];

    assign d_s[0] = line_i;
    assign h_s[0] = mask_i;

    for (genvar g = 0; g < HALF; g++) begin : g_stage
        wdc_squeeze_stage #(.WORDS(WORDS), .WORD_W(WORD_W)) u_sq (
            .data_i (d_s[g]),
            .hole_i (h_s[g]),
            .data_o (d_s[g+1]),
            .hole_o (h_s[g+1])
        );
    end

    assign half_o = d_s[HALF][HALF_W-1:0];
endmodule

// File: rtl/wdc_half_scatter.sv
// Write side for one physical line: WORDS/2 insertion stages plus enables.
module wdc_half_scatter #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic [(WORDS/2)*WORD_W-1:0] half_i,
    input  logic [WORDS-1:0]            mask_i,
    output logic [WORDS*WORD_W-1:0]     line_o,
    output logic [WORDS-1:0]            we_o
);
    localparam int HALF  = WORDS / 2;
    localparam int CNT_W = $clog2(WORDS + 1);

    logic [WORDS*WORD_W-1:0] d_s [HALF+1];
    logic [WORDS-1:0]        p_s [HALF+1];

    assign d_s[0] = {{((WORDS-HALF)*WORD_W){1'b0}}, half_i};
    assign p_s[0] = mask_i;

    for (genvar g = 0; g < HALF; g++) begin : g_stage
        wdc_spread_stage #(.WORDS(WORDS), .WORD_W(WORD_W)) u_sp (
            .data_i (d_s[g]),
            .pend_i (p_s[g]),
            .data_o (d_s[g+1]),
            .pend_o (p_s[g+1])
        );
    end

    assign line_o = d_s[HALF];

    // Enable only the first HALF healthy slots.
    always_comb begin
        logic [CNT_W-1:0] seen;
        seen = '0;
        for (int i = 0; i < WORDS; i++) begin
            we_o[i] = !mask_i[i] && (int'(seen) < HALF);
            if (!mask_i[i]) seen = seen + 1'b1;
        end
    end
endmodule

// File: rtl/wdc_line_compactor.sv
module wdc_line_compactor
    import wdc_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    paired_i,
    input  logic [WORDS-1:0]        mask_a_i,
    input  logic [WORDS-1:0]        mask_b_i,
    input  logic                    rd_vld_i,
    input  logic [WORDS*WORD_W-1:0] rd_a_i,
    input  logic [WORDS*WORD_W-1:0] rd_b_i,
    input  logic                    wr_vld_i,
    input  logic [WORDS*WORD_W-1:0] wr_line_i,
    output logic                    rd_vld_o,
    output logic                    rd_ok_o,
    output logic                    rd_err_o,
    output logic [WORDS*WORD_W-1:0] rd_line_o,
    output logic                    wr_vld_o,
    output logic                    wr_err_o,
    output logic [WORDS*WORD_W-1:0] wr_a_o,
    output logic [WORDS*WORD_W-1:0] wr_b_o,
    output logic [WORDS-1:0]        wr_be_a_o,
    output logic [WORDS-1:0]        wr_be_b_o
);
    localparam int HALF   = WORDS / 2;
    localparam int LINE_W = WORDS * WORD_W;
    localparam int HALF_W = HALF * WORD_W;

    wdc_mode_e mode;
    assign mode = wdc_mode_e'(paired_i);

    logic over_a, over_b, too_many;
    assign over_a   = $countones(mask_a_i) > HALF;
    assign over_b   = $countones(mask_b_i) > HALF;
    assign too_many = (mode == MODE_PAIRED) && (over_a || over_b);

    // ---------------- read gather ----------------
    logic [HALF_W-1:0] lo_half, hi_half;

    wdc_half_gather #(.WORDS(WORDS), .WORD_W(WORD_W)) u_gather_a (
        .line_i (rd_a_i), .mask_i (mask_a_i), .half_o (lo_half)
    );
    wdc_half_gather #(.WORDS(WORDS), .WORD_W(WORD_W)) u_gather_b (
        .line_i (rd_b_i), .mask_i (mask_b_i), .half_o (hi_half)
    );

    logic [LINE_W-1:0] rd_line_d;
    always_comb begin
        unique case (mode)
            MODE_DIRECT: rd_line_d = rd_a_i;
            MODE_PAIRED: rd_line_d = too_many ? '0 : {hi_half, lo_half};
            default:     rd_line_d = '0;
        endcase
    end

    // ---------------- write scatter ----------------
    logic [LINE_W-1:0] sc_a, sc_b;
    logic [WORDS-1:0]  we_a, we_b;

    wdc_half_scatter #(.WORDS(WORDS), .WORD_W(WORD_W)) u_scatter_a (
        .half_i (wr_line_i[HALF_W-1:0]), .mask_i (mask_a_i),
        .line_o (sc_a), .we_o (we_a)
    );
    wdc_half_scatter #(.WORDS(WORDS), .WORD_W(WORD_W)) u_scatter_b (
        .half_i (wr_line_i[LINE_W-1:HALF_W]), .mask_i (mask_b_i),
        .line_o (sc_b), .we_o (we_b)
    );

    logic [LINE_W-1:0] wr_a_d, wr_b_d;
    logic [WORDS-1:0]  be_a_d, be_b_d;
    always_comb begin
        unique case (mode)
            MODE_DIRECT: begin
                wr_a_d = wr_line_i;
                wr_b_d = '0;
                be_a_d = '1;
                be_b_d = '0;
            end
            MODE_PAIRED: begin
                wr_a_d = sc_a;
                wr_b_d = sc_b;
                be_a_d = too_many ? '0 : we_a;
                be_b_d = too_many ? '0 : we_b;
            end
            default: begin
                wr_a_d = '0;
                wr_b_d = '0;
                be_a_d = '0;
                be_b_d = '0;
            end
        endcase
    end

    // ---------------- output registers (one cycle) ----------------
    logic rd_vld_q, rd_err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_err_q  <= 1'b0;
            rd_line_o <= '0;
        end else begin
            rd_vld_q <= rd_vld_i;
            if (rd_vld_i) begin
                rd_err_q  <= too_many;
                rd_line_o <= rd_line_d;
            end
        end
    end

    assign rd_vld_o = rd_vld_q;
    assign rd_err_o = rd_vld_q & rd_err_q;
    assign rd_ok_o  = rd_vld_q & ~rd_err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_vld_o  <= 1'b0;
            wr_err_o  <= 1'b0;
            wr_a_o    <= '0;
            wr_b_o    <= '0;
            wr_be_a_o <= '0;
            wr_be_b_o <= '0;
        end else begin
            wr_vld_o  <= wr_vld_i;
            wr_err_o  <= wr_vld_i & too_many;
            wr_be_a_o <= wr_vld_i ? be_a_d : '0;
            wr_be_b_o <= wr_vld_i ? be_b_d : '0;
            if (wr_vld_i) begin
                wr_a_o <= wr_a_d;
                wr_b_o <= wr_b_d;
            end
        end
    end

    // ---------------- assertions ----------------
    // R6
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld_o |-> $past(rd_vld_i));

    // R1
    direct_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_o && !$past(paired_i)) |-> !rd_err_o);

    // R7
    wr_skip_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld_o && $past(paired_i)) |->
            (((wr_be_a_o & $past(mask_a_i)) == '0) && ((wr_be_b_o & $past(mask_b_i)) == '0)));

    // R7
    wr_half_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld_o && $past(paired_i) && !wr_err_o) |->
            ($countones(wr_be_a_o) == HALF && $countones(wr_be_b_o) == HALF));
endmodule

// File: tb/wdc_line_compactor_tb.sv
module wdc_line_compactor_tb;
    localparam int W  = 8;
    localparam int N  = 8;
    localparam int NV = 9;

    localparam logic [7:0] VMA [NV] = '{8'h00, 8'h01, 8'h0F, 8'hAA, 8'h81, 8'h1F, 8'h00, 8'hFF, 8'h3C};
    localparam logic [7:0] VMB [NV] = '{8'h00, 8'h80, 8'hF0, 8'h55, 8'h18, 8'h00, 8'hF1, 8'hFF, 8'hC3};
    localparam logic       VMD [NV] = '{1'b1,  1'b1,  1'b1,  1'b1,  1'b1,  1'b1,  1'b1,  1'b0,  1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic paired_i = 1'b0;
    logic [N-1:0] mask_a_i = '0, mask_b_i = '0;
    logic rd_vld_i = 1'b0, wr_vld_i = 1'b0;
    logic [N*W-1:0] rd_a_i = '0, rd_b_i = '0, wr_line_i = '0;
    logic rd_vld_o, rd_ok_o, rd_err_o, wr_vld_o, wr_err_o;
    logic [N*W-1:0] rd_line_o, wr_a_o, wr_b_o;
    logic [N-1:0] wr_be_a_o, wr_be_b_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    wdc_line_compactor #(.WORDS(N), .WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .paired_i(paired_i),
        .mask_a_i(mask_a_i), .mask_b_i(mask_b_i),
        .rd_vld_i(rd_vld_i), .rd_a_i(rd_a_i), .rd_b_i(rd_b_i),
        .wr_vld_i(wr_vld_i), .wr_line_i(wr_line_i),
        .rd_vld_o(rd_vld_o), .rd_ok_o(rd_ok_o), .rd_err_o(rd_err_o), .rd_line_o(rd_line_o),
        .wr_vld_o(wr_vld_o), .wr_err_o(wr_err_o), .wr_a_o(wr_a_o), .wr_b_o(wr_b_o),
        .wr_be_a_o(wr_be_a_o), .wr_be_b_o(wr_be_b_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int ones(input logic [7:0] m);
        int c = 0;
        for (int i = 0; i < 8; i++) c += m[i];
        return c;
    endfunction

    // first four healthy words, lowest index first
    function automatic logic [31:0] pick(input logic [63:0] ln, input logic [7:0] m);
        logic [31:0] r = '0;
        int k = 0;
        for (int i = 0; i < 8; i++)
            if (!m[i] && k < 4) begin
                r[k*8 +: 8] = ln[i*8 +: 8];
                k++;
            end
        return r;
    endfunction

    function automatic logic [63:0] place(input logic [31:0] h, input logic [7:0] m);
        logic [63:0] r = '0;
        int k = 0;
        for (int i = 0; i < 8; i++)
            if (!m[i] && k < 4) begin
                r[i*8 +: 8] = h[k*8 +: 8];
                k++;
            end
        return r;
    endfunction

    function automatic logic [7:0] slots(input logic [7:0] m);
        logic [7:0] r = '0;
        int k = 0;
        for (int i = 0; i < 8; i++)
            if (!m[i] && k < 4) begin
                r[i] = 1'b1;
                k++;
            end
        return r;
    endfunction

    function automatic logic [63:0] bytemask(input logic [7:0] be);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = {8{be[i]}};
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            rd_a_i[i*W +: W]    = 8'hA0 + 8'(i);
            rd_b_i[i*W +: W]    = 8'hB0 + 8'(i);
            wr_line_i[i*W +: W] = 8'hC0 + 8'(i);
        end
        // R10: requests during reset produce nothing
        rd_vld_i = 1'b1;
        wr_vld_i = 1'b1;
        paired_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "rd_vld_o", 64'(rd_vld_o), 64'd0);
        chk("R10", "rd_ok_o", 64'(rd_ok_o), 64'd0);
        chk("R10", "rd_err_o", 64'(rd_err_o), 64'd0);
        chk("R10", "wr_vld/err", {wr_vld_o, wr_err_o}, 64'd0);
        chk("R10", "wr_be", {wr_be_a_o, wr_be_b_o}, 64'd0);
        rd_vld_i = 1'b0;
        wr_vld_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R6: result not visible before the capturing edge, visible after it
        rd_vld_i = 1'b1;
        paired_i = 1'b0;
        #1;
        chk("R6", "rd_vld_o before edge", 64'(rd_vld_o), 64'd0);
        @(negedge clk);
        chk("R6", "rd_vld_o after edge", 64'(rd_vld_o), 64'd1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic exp_err;
            logic [63:0] exp_line, exp_wa, exp_wb;
            logic [7:0]  exp_ba, exp_bb;
            string rq_lo, rq_hi, rq_wr;
            paired_i = VMD[v];
            mask_a_i = VMA[v];
            mask_b_i = VMB[v];
            rd_vld_i = 1'b1;
            wr_vld_i = 1'b1;
            exp_err = VMD[v] && (ones(VMA[v]) > 4 || ones(VMB[v]) > 4);
            if (!VMD[v]) begin
                exp_line = rd_a_i;
                exp_wa = wr_line_i; exp_wb = '0; exp_ba = 8'hFF; exp_bb = 8'h00;
                rq_lo = "R1"; rq_hi = "R1"; rq_wr = "R8";
            end else if (exp_err) begin
                exp_line = '0;
                exp_wa = '0; exp_wb = '0; exp_ba = '0; exp_bb = '0;
                rq_lo = "R5"; rq_hi = "R5"; rq_wr = "R9";
            end else begin
                exp_line = {pick(rd_b_i, VMB[v]), pick(rd_a_i, VMA[v])};
                exp_wa = place(wr_line_i[31:0], VMA[v]);
                exp_wb = place(wr_line_i[63:32], VMB[v]);
                exp_ba = slots(VMA[v]);
                exp_bb = slots(VMB[v]);
                rq_lo = (ones(VMA[v]) == 4) ? "R4" : "R2";
                rq_hi = (ones(VMB[v]) == 4) ? "R4" : "R3";
                rq_wr = "R7";
            end
            @(negedge clk);
            chk("R6", $sformatf("v%0d rd_vld_o", v), 64'(rd_vld_o), 64'd1);
            chk(exp_err ? "R5" : rq_lo, $sformatf("v%0d rd_err_o", v), 64'(rd_err_o), 64'(exp_err));
            chk(exp_err ? "R5" : rq_lo, $sformatf("v%0d rd_ok_o", v), 64'(rd_ok_o), 64'(!exp_err));
            chk(rq_lo, $sformatf("v%0d lower half", v), 64'(rd_line_o[31:0]), 64'(exp_line[31:0]));
            chk(rq_hi, $sformatf("v%0d upper half", v), 64'(rd_line_o[63:32]), 64'(exp_line[63:32]));
            chk(rq_wr, $sformatf("v%0d wr_err_o", v), 64'(wr_err_o), 64'(exp_err));
            chk(rq_wr, $sformatf("v%0d wr_be_a", v), 64'(wr_be_a_o), 64'(exp_ba));
            chk(rq_wr, $sformatf("v%0d wr_be_b", v), 64'(wr_be_b_o), 64'(exp_bb));
            chk(rq_wr, $sformatf("v%0d wr_a data", v), wr_a_o & bytemask(exp_ba), exp_wa & bytemask(exp_ba));
            chk(rq_wr, $sformatf("v%0d wr_b data", v), wr_b_o & bytemask(exp_bb), exp_wb & bytemask(exp_bb));
        end

        // R6: idle cycle after traffic clears valids and enables
        rd_vld_i = 1'b0;
        wr_vld_i = 1'b0;
        paired_i = 1'b0;
        mask_a_i = 8'h00;
        @(negedge clk);
        chk("R6", "idle rd_vld_o", 64'(rd_vld_o), 64'd0);
        chk("R6", "idle wr_vld_o", 64'(wr_vld_o), 64'd0);
        chk("R6", "idle wr_be", {wr_be_a_o, wr_be_b_o}, 64'd0);

        // R3: upper half taken from top of B when B loses its low words
        paired_i = 1'b1;
        mask_a_i = 8'h00;
        mask_b_i = 8'h0F;
        rd_vld_i = 1'b1;
        @(negedge clk);
        chk("R3", "B upper words", 64'(rd_line_o[63:32]), 64'hB7B6B5B4);
        chk("R2", "A lower words", 64'(rd_line_o[31:0]), 64'hA3A2A1A0);
        rd_vld_i = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule